// File: doc/BRIEF.md
# Secure-Banked Priority Mask Register

This block is the priority-mask slice of an interrupt controller's CPU interface. It holds an 8-bit priority mask and also shows the current running priority, which arrives from elsewhere as an input. Both values can be reached through a register access port. Every request on that port carries a secure/non-secure qualifier. The block also makes the final interrupt-signal decision, gated by the mask and by the running priority.

When the security extension is fitted, Group 0 interrupts may be routed to the secure monitor. In that case a non-secure access works in a folded priority space. Raw values with the top bit clear belong to the secure side and read back as zero. Raw values with the top bit set are stretched over the whole range by a left shift. Non-secure writes are folded back with a right shift and a forced top bit. They are refused outright while the stored mask is still in the secure half.

The request channel has no back-pressure: a request is accepted on every cycle that `req_valid` is high, and `req_valid` is its only handshake. A read answers with `rsp_valid` and `rsp_rdata` exactly one cycle later. No response is produced for a write.

Top module: `pmask_bank`

## Requirements
- R1: Reset sets the stored mask to 0x00 and drives `rsp_valid` and `irq_out` low.
- R2: An access is folded only when `sec_ext_en`, `g0_to_mon` and `req_ns` are all high. In every other case a read returns the raw value and a write stores `req_wdata` unchanged.
- R3: A folded read of a value whose bit 7 is 0 returns 0x00.
- R4: A folded read of a value with bit 7 set, other than 0xFF, returns the value shifted left by one and truncated to 8 bits (for example 0x90 reads as 0x20).
- R5: A folded read of 0xFF returns 0xFF.
- R6: A folded write to the mask is dropped with no effect while bit 7 of the stored mask is 0.
- R7: A folded write that is accepted stores `{1, req_wdata[7:1]}`, so 0xFE and 0xFF both store 0xFF.
- R8: `req_sel` = 0 selects the mask and `req_sel` = 1 selects the running priority. Reads of the running priority follow the same folding rules as reads of the mask. Writes with `req_sel` = 1 change nothing.
- R9: `rsp_valid` is high for exactly the one cycle after each read request and never follows a write. `rsp_rdata` carries the value as it stood in the request cycle.
- R10: `irq_out` is a register. In the cycle after edge k it equals `pend_valid && pend_prio < mask && pend_prio < run_prio`, using the input values sampled at edge k and the mask as it stood just before edge k. A mask write accepted at edge k therefore affects `irq_out` from edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_ext_en | input | 1 | Security extension is fitted |
| g0_to_mon | input | 1 | Group 0 is routed to the secure monitor |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = mask, 1 = running priority |
| req_ns | input | 1 | Request comes from the non-secure side |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data is valid |
| rsp_rdata | output | 8 | Read data |
| run_prio | input | 8 | Current running priority (0xFF when idle) |
| pend_valid | input | 1 | A candidate interrupt is pending |
| pend_prio | input | 8 | Priority of the pending candidate |
| irq_out | output | 1 | Interrupt signal to the processor |

## Verification
A mask write and the interrupt decision can happen in the same cycle, because the decision logic keeps reading the mask while a request updates it. The bench holds a pending interrupt steady and issues a mask write that moves the threshold across the pending priority. It does this in both directions. It then checks that `irq_out` still shows the old mask in the first cycle after the write edge and shows the new mask one cycle later. A second overlap is a folded write arriving while the stored mask sits in the secure half. The refusal is judged by reading the mask back raw afterwards.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_RUN  = 1'b1
  } pm_sel_e;

  localparam int NUM_SRC = 2;
endpackage

// File: rtl/pmask_rd_view.sv
// Maps a raw priority into the view seen by the requester.
module pmask_rd_view #(
  parameter int W = 8
) (
  input  logic         xlate,
  input  logic [W-1:0] raw,
  output logic [W-1:0] view
);
  localparam int TOP = W - 1;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  always_comb begin
    if (!xlate) begin
      view = raw;
    end else if (!raw[TOP]) begin
      view = '0;                    // secure half is hidden
    end else if (raw == ONES) begin
      view = raw;                   // all-ones is a fixed point
    end else begin
      view = {raw[TOP-1:0], 1'b0};
    end
  end
endmodule

// File: rtl/pmask_wr_path.sv
// Stored priority mask and its write-acceptance rule.
module pmask_wr_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         xlate,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  localparam int TOP = W - 1;

  logic         accept;
  logic [W-1:0] mask_d;

  always_comb begin
    accept = wr_en && (!xlate || mask_q[TOP]);
    mask_d = xlate ? {1'b1, wdata[TOP:1]} : wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (accept) begin
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/pmask_gate.sv
// Registered interrupt-signal decision.
module pmask_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pend_valid,
  input  logic [W-1:0] pend_prio,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] run_prio,
  output logic         irq_q
);
  logic below_mask;
  logic below_run;

  always_comb begin
    below_mask = pend_prio < mask;
    below_run  = pend_prio < run_prio;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= pend_valid && below_mask && below_run;
    end
  end
endmodule

// File: rtl/pmask_bank.sv
module pmask_bank #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_ext_en,
  input  logic              g0_to_mon,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_sel,
  input  logic              req_ns,
  input  logic [PRIO_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [PRIO_W-1:0] rsp_rdata,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              irq_out
);
  import pmask_pkg::*;

  logic              xlate;
  logic              mask_wr;
  logic              rd_req;
  logic [PRIO_W-1:0] mask_q;
  logic [PRIO_W-1:0] src_raw  [NUM_SRC];
  logic [PRIO_W-1:0] src_view [NUM_SRC];

  always_comb begin
    xlate   = sec_ext_en && g0_to_mon && req_ns;
    mask_wr = req_valid && req_write && (pm_sel_e'(req_sel) == SEL_MASK);
    rd_req  = req_valid && !req_write;
    src_raw[SEL_MASK] = mask_q;
    src_raw[SEL_RUN]  = run_prio;
  end

  pmask_wr_path #(.W(PRIO_W)) u_wr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (mask_wr),
    .xlate (xlate),
    .wdata (req_wdata),
    .mask_q(mask_q)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_view
    pmask_rd_view #(.W(PRIO_W)) u_view (
      .xlate(xlate),
      .raw  (src_raw[g]),
      .view (src_view[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) begin
        rsp_rdata <= src_view[req_sel];
      end
    end
  end

  pmask_gate #(.W(PRIO_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_valid(pend_valid),
    .pend_prio (pend_prio),
    .mask      (mask_q),
    .run_prio  (run_prio),
    .irq_q     (irq_out)
  );
endmodule

// File: rtl/pmask_bank_chk.sv
module pmask_bank_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sec_ext_en,
  input logic         g0_to_mon,
  input logic         req_valid,
  input logic         req_write,
  input logic         req_sel,
  input logic         req_ns,
  input logic [W-1:0] mask_q,
  input logic         rsp_valid,
  input logic [W-1:0] rsp_rdata,
  input logic         pend_valid,
  input logic [W-1:0] pend_prio,
  input logic         irq_out
);
  logic fold;
  assign fold = sec_ext_en && g0_to_mon && req_ns;

  // R9
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  // R6
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_sel && fold && !mask_q[W-1]) |=> $stable(mask_q));

  // R7
  folded_topbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_sel && fold && mask_q[W-1]) |=> mask_q[W-1]);

  // R8
  run_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_sel) |=> $stable(mask_q));

  // R3
  secure_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_sel && fold && !mask_q[W-1]) |=> (rsp_rdata == '0));

  // R10
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(pend_valid && (pend_prio < mask_q)));
endmodule

bind pmask_bank pmask_bank_chk #(.W(PRIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sec_ext_en(sec_ext_en),
  .g0_to_mon (g0_to_mon),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_sel   (req_sel),
  .req_ns    (req_ns),
  .mask_q    (mask_q),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .pend_valid(pend_valid),
  .pend_prio (pend_prio),
  .irq_out   (irq_out)
);

// File: tb/sim_pmask_bank.sv
`timescale 1ns/1ps
module sim_pmask_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_ext_en = 1'b0, g0_to_mon = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_sel = 1'b0, req_ns = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic [7:0] run_prio = 8'hFF;
  logic       pend_valid = 1'b0;
  logic [7:0] pend_prio = '0;
  logic       irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pmask_bank u0 (
    .clk(clk), .rst_n(rst_n), .sec_ext_en(sec_ext_en), .g0_to_mon(g0_to_mon),
    .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel), .req_ns(req_ns),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .run_prio(run_prio), .pend_valid(pend_valid), .pend_prio(pend_prio), .irq_out(irq_out)
  );

  // {req no, ctl = sec,g0,ns,wr, sel, wdata, run, expected read}
  localparam int NV = 30;
  localparam logic [39:0] VEC [NV] = '{
    40'h01_C_0_00_FF_00,  // R1 raw read after reset
    40'h06_F_0_AA_FF_00,  // R6 folded write, mask in secure half
    40'h06_C_0_00_FF_00,  // R6 mask unchanged
    40'h02_D_0_90_FF_00,  // R2 raw write
    40'h04_E_0_00_FF_20,  // R4 folded read 0x90
    40'h02_A_0_00_FF_90,  // R2 g0 routing off
    40'h02_6_0_00_FF_90,  // R2 extension absent
    40'h02_B_0_91_FF_00,  // R2 ns write, routing off
    40'h02_C_0_00_FF_91,  // R2 raw readback
    40'h07_F_0_40_FF_00,  // R7 folded write 0x40
    40'h07_C_0_00_FF_A0,  // R7 stored 0xA0
    40'h04_E_0_00_FF_40,  // R4 folded read 0xA0
    40'h07_F_0_FE_FF_00,  // R7 folded write 0xFE
    40'h07_C_0_00_FF_FF,  // R7 stored 0xFF
    40'h05_E_0_00_FF_FF,  // R5 fixed point
    40'h07_F_0_01_FF_00,  // R7 folded write 0x01
    40'h07_C_0_00_FF_80,  // R7 stored 0x80
    40'h04_E_0_00_FF_00,  // R4 0x80 reads 0x00
    40'h07_F_0_FF_FF_00,  // R7 folded write 0xFF
    40'h07_C_0_00_FF_FF,  // R7 stored 0xFF
    40'h02_D_0_7F_FF_00,  // R2 raw write 0x7F
    40'h03_E_0_00_FF_00,  // R3 secure value hidden
    40'h06_F_0_FF_FF_00,  // R6 refused
    40'h06_C_0_00_FF_7F,  // R6 still 0x7F
    40'h08_D_1_12_FF_00,  // R8 write to running priority
    40'h08_C_0_00_FF_7F,  // R8 mask untouched
    40'h08_E_1_00_C0_80,  // R8 folded run read 0xC0
    40'h08_E_1_00_30_00,  // R8 folded run read secure half
    40'h08_E_1_00_FF_FF,  // R8 folded run read 0xFF
    40'h08_C_1_00_30_30   // R8 raw run read
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic access(input logic [3:0] ctl, input logic sel, input logic [7:0] wd);
    @(negedge clk);
    {sec_ext_en, g0_to_mon, req_ns, req_write} = ctl;
    req_sel = sel;
    req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    pend_valid = 1'b1;
    pend_prio = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", {7'd0, rsp_valid}, 8'h00);
    check("R1 irq_out", {7'd0, irq_out}, 8'h00);
    pend_valid = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_prio = VEC[i][15:8];
      access(VEC[i][31:28], VEC[i][24], VEC[i][23:16]);
      if (!VEC[i][28]) begin
        check($sformatf("R%0d vec%0d", VEC[i][39:32], i), rsp_rdata, VEC[i][7:0]);
      end
    end

    // R9 response timing
    run_prio = 8'hFF;
    access(4'hC, 1'b0, 8'h00);
    check("R9 rsp high after read", {7'd0, rsp_valid}, 8'h01);
    @(negedge clk);
    check("R9 rsp one cycle", {7'd0, rsp_valid}, 8'h00);
    access(4'hD, 1'b0, 8'h80);
    check("R9 no rsp after write", {7'd0, rsp_valid}, 8'h00);

    // R10 gating, mask now 0x80
    pend_valid = 1'b1; pend_prio = 8'h40; run_prio = 8'hFF;
    @(negedge clk);
    check("R10 below both", {7'd0, irq_out}, 8'h01);
    pend_prio = 8'h80;
    @(negedge clk);
    check("R10 equal mask", {7'd0, irq_out}, 8'h00);
    pend_prio = 8'h40; run_prio = 8'h40;
    @(negedge clk);
    check("R10 equal running", {7'd0, irq_out}, 8'h00);
    run_prio = 8'h41;
    @(negedge clk);
    check("R10 below running", {7'd0, irq_out}, 8'h01);
    pend_valid = 1'b0;
    @(negedge clk);
    check("R10 nothing pending", {7'd0, irq_out}, 8'h00);

    // R10 mask write overlapping the decision
    pend_valid = 1'b1; pend_prio = 8'h90; run_prio = 8'hFF;
    @(negedge clk);
    check("R10 before raise", {7'd0, irq_out}, 8'h00);
    access(4'hD, 1'b0, 8'hA0);
    check("R10 old mask seen", {7'd0, irq_out}, 8'h00);
    @(negedge clk);
    check("R10 new mask seen", {7'd0, irq_out}, 8'h01);
    access(4'hD, 1'b0, 8'h10);
    check("R10 old mask kept", {7'd0, irq_out}, 8'h01);
    @(negedge clk);
    check("R10 lowered mask", {7'd0, irq_out}, 8'h00);
    pend_valid = 1'b0;

    // R1 reset mid-run clears the mask
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(4'hC, 1'b0, 8'h00);
    check("R1 mask cleared", rsp_rdata, 8'h00);

    finish_run();
  end
endmodule